// File: doc/BRIEF.md
# I2C Burst Receive Engine

This block collects a run of bytes from an I2C bus on behalf of software. One write to the receive control word arms it with a byte count and a flag that selects whether the final byte of the run is refused. The engine then asks a byte-level I2C receiver for one byte at a time. With every request it states whether the receiver should acknowledge that byte. Each byte that comes back is stored in a 64-entry receive queue. When the last byte of the run has been stored, a sticky read-complete flag rises.

Software empties the queue through a read-data port. Each read returns the oldest byte and removes it. A long read is split into runs of at most 64 bytes, and the refuse-last flag is set only on the final run, so that only the very last byte of the whole transfer is refused. START, STOP and addressing belong to other logic.

Top module: `i2c_burst_rx`

## Requirements
- R1: A control write (`ctl_wr`) made while idle, with a non-zero count in `ctl_wdata[6:0]`, starts a run. The run raises one request on `brx_req` per byte, and each `brx_done` pulse completes one byte.
- R2: When `ctl_wdata[7]` is 1, `brx_nak` is 1 during the request for the final byte of the run and 0 during every other request. When `ctl_wdata[7]` is 0, `brx_nak` is 0 for every byte. `brx_nak` does not change while a request is pending.
- R3: Bytes are stored in arrival order. `rd_data` shows the oldest stored byte, and a cycle with `rd_pop` high removes it.
- R4: `rx_empty` is 1 exactly when no byte is stored.
- R5: `rd_done` is 1 in the cycle after the `brx_done` of the final byte of a run, and stays set until a write with `isr_wr` high and `isr_wdata[4]` = 1. A write that leaves bit 4 at 0 does not clear it.
- R6: A control write with a count of 0 raises no request and does not set `rd_done`.
- R7: A control write made while a run is in progress is ignored.
- R8: While the queue is empty, `rd_data` is 0 and `rd_pop` changes nothing.
- R9: A count above 64 is treated as 64.
- R10: No request is raised while the queue is full. The run resumes once a byte has been removed.
- R11: `brx_req` falls in the cycle after `brx_done`. At least one cycle with no request separates two bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe of the receive control word |
| ctl_wdata | input | 8 | [6:0] byte count, [7] refuse final byte |
| isr_wr | input | 1 | Write strobe of the interrupt status word |
| isr_wdata | input | 8 | Bit 4 = 1 clears read-complete |
| rd_pop | input | 1 | Read of the read-data port; removes the oldest byte |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| rx_empty | output | 1 | Receive queue empty |
| rd_done | output | 1 | Read-complete flag |
| brx_req | output | 1 | Byte request to the byte receiver |
| brx_nak | output | 1 | Refuse this byte (valid with `brx_req`) |
| brx_done | input | 1 | Byte receiver finished the requested byte |
| brx_data | input | 8 | Received byte, valid with `brx_done` |

## Verification
The bench aims at the refuse flag on the final byte. A design that counted off by one would refuse the second-to-last byte, or none at all. Runs that are ignored are also covered: zero counts and writes made mid-run. A design that restarted on those would deliver extra bytes or raise read-complete too early.

A run longer than 64 bytes must be clamped to 64. The bench also starts a run while the queue is already full. A design without the stall would overwrite unread bytes, and the drained data order would expose that. Finally, the bench pops the queue while it is empty. A design that moved its pointers on that pop would later return a stale byte or report the wrong empty state.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int CTL_CNT_W     = 7;
  localparam int CTL_NAK_BIT   = 7;
  localparam int ISR_RDONE_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_REQ  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PTR_W:0] wptr_q, rptr_q, wptr_d, rptr_d;
  logic do_push, do_pop;

  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q[PTR_W-1:0] == rptr_q[PTR_W-1:0]) &&
                   (wptr_q[PTR_W] != rptr_q[PTR_W]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_push) wptr_d = wptr_q + 1'b1;
    if (do_pop)  rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q[PTR_W-1:0]] <= push_data;
  end

  assign head = empty ? '0 : mem[rptr_q[PTR_W-1:0]];
endmodule

// File: rtl/rxb_seq.sv
module rxb_seq
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic [CTL_CNT_W:0]   ctl_wdata,
  input  logic                 q_full,
  output logic                 brx_req,
  output logic                 brx_nak,
  input  logic                 brx_done,
  input  logic [DW-1:0]        brx_data,
  output logic                 push,
  output logic [DW-1:0]        push_data,
  output logic                 run_end,
  output logic                 busy
);
  localparam int LEFT_W = $clog2(DEPTH + 1);

  seq_st_e st_q, st_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic nlast_q, nlast_d;
  logic [LEFT_W-1:0] cnt_clamped;
  int unsigned field_n;
  logic last_byte;

  always_comb begin
    field_n = int'(ctl_wdata[CTL_CNT_W-1:0]);
    if (field_n > DEPTH) cnt_clamped = LEFT_W'(DEPTH);
    else                 cnt_clamped = LEFT_W'(field_n);
  end

  assign last_byte = (left_q == LEFT_W'(1));
  assign busy      = (st_q != ST_IDLE);
  assign brx_req   = (st_q == ST_REQ);
  assign brx_nak   = nlast_q && last_byte;
  assign push      = brx_req && brx_done;
  assign push_data = brx_data;
  assign run_end   = push && last_byte;

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    nlast_d = nlast_q;
    case (st_q)
      ST_IDLE: begin
        if (ctl_wr && (cnt_clamped != '0)) begin
          left_d  = cnt_clamped;
          nlast_d = ctl_wdata[CTL_NAK_BIT];
          st_d    = ST_GAP;
        end
      end
      ST_GAP: begin
        if (!q_full) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (brx_done) begin
          left_d = left_q - 1'b1;
          st_d   = last_byte ? ST_IDLE : ST_GAP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      left_q  <= '0;
      nlast_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      left_q  <= left_d;
      nlast_q <= nlast_d;
    end
  end
endmodule

// File: rtl/rxb_flag.sv
module rxb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/i2c_burst_rx.sv
module i2c_burst_rx
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          isr_wr,
  input  logic [7:0]    isr_wdata,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rx_empty,
  output logic          rd_done,
  output logic          brx_req,
  output logic          brx_nak,
  input  logic          brx_done,
  input  logic [DW-1:0] brx_data
);
  logic [1:0] rst_sync_q;
  logic rst_ns;
  logic q_push, q_full, run_end, busy;
  logic [DW-1:0] q_wdata;
  logic rdone_clr;
  logic unused_isr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  assign rdone_clr       = isr_wr && isr_wdata[ISR_RDONE_BIT];
  assign unused_isr_bits = ^{isr_wdata[7:ISR_RDONE_BIT+1], isr_wdata[ISR_RDONE_BIT-1:0]};

  rxb_seq #(.DW(DW), .DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .q_full    (q_full),
    .brx_req   (brx_req),
    .brx_nak   (brx_nak),
    .brx_done  (brx_done),
    .brx_data  (brx_data),
    .push      (q_push),
    .push_data (q_wdata),
    .run_end   (run_end),
    .busy      (busy)
  );

  rxb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_ns),
    .push      (q_push),
    .push_data (q_wdata),
    .pop       (rd_pop),
    .head      (rd_data),
    .empty     (rx_empty),
    .full      (q_full)
  );

  rxb_flag u_rdone (
    .clk   (clk),
    .rst_n (rst_ns),
    .set   (run_end),
    .clr   (rdone_clr),
    .q     (rd_done)
  );
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic          isr_wr,
  input logic [7:0]    isr_wdata,
  input logic          rd_pop,
  input logic [DW-1:0] rd_data,
  input logic          rx_empty,
  input logic          rd_done,
  input logic          brx_req,
  input logic          brx_nak,
  input logic          brx_done,
  input logic          q_full,
  input logic          busy
);
  p_req_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brx_req |-> !q_full);

  p_nak_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (brx_req && !brx_done) |=> (brx_req && $stable(brx_nak)));

  p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (brx_req && brx_done) |=> !brx_req);

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rd_data == '0));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rd_pop && !(brx_req && brx_done)) |=> rx_empty);

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !(isr_wr && isr_wdata[4])) |=> rd_done);

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done) |-> $past(brx_req && brx_done));

  p_zero_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_wr && (ctl_wdata[6:0] == 7'd0)) |=> !busy);
endmodule

bind i2c_burst_rx rxb_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .isr_wr    (isr_wr),
  .isr_wdata (isr_wdata),
  .rd_pop    (rd_pop),
  .rd_data   (rd_data),
  .rx_empty  (rx_empty),
  .rd_done   (rd_done),
  .brx_req   (brx_req),
  .brx_nak   (brx_nak),
  .brx_done  (brx_done),
  .q_full    (q_full),
  .busy      (busy)
);

// File: tb/sim_i2c_burst_rx.sv
`timescale 1ns/1ps
module sim_i2c_burst_rx;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, isr_wr, rd_pop, brx_done;
  logic [7:0] ctl_wdata, isr_wdata, brx_data, rd_data;
  logic rx_empty, rd_done, brx_req, brx_nak;

  int total = 0;
  int bad = 0;
  int exp_len = 0;
  bit exp_nak = 1'b0;
  int req_cnt = 0;
  int delivered = 0;
  logic [7:0] next_val = 8'h5A;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  i2c_burst_rx u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .isr_wr(isr_wr), .isr_wdata(isr_wdata), .rd_pop(rd_pop), .rd_data(rd_data),
    .rx_empty(rx_empty), .rd_done(rd_done), .brx_req(brx_req), .brx_nak(brx_nak),
    .brx_done(brx_done), .brx_data(brx_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // byte receiver model: feeds the expected-value queue
  initial begin
    brx_done = 1'b0;
    brx_data = 8'h00;
    forever begin
      @(negedge clk);
      if (brx_req === 1'b1) begin
        bit nak_seen;
        bit last;
        req_cnt++;
        nak_seen = brx_nak;
        chk(nak_seen == (exp_nak && req_cnt == exp_len), "R2", "nak per byte",
            int'(nak_seen), int'(exp_nak && req_cnt == exp_len));
        repeat (LAT) @(negedge clk);
        chk(brx_nak == nak_seen, "R2", "nak held", int'(brx_nak), int'(nak_seen));
        brx_data = next_val;
        brx_done = 1'b1;
        exp_q.push_back(next_val);
        last = (req_cnt == exp_len);
        @(negedge clk);
        brx_done = 1'b0;
        delivered++;
        next_val = next_val + 8'd37;
        chk(brx_req == 1'b0, "R11", "req drops after done", int'(brx_req), 0);
        if (last) chk(rd_done == 1'b1, "R5", "rd_done after final byte", int'(rd_done), 1);
      end
    end
  end

  task automatic start_run(input int n, input bit nl, input bit track);
    @(negedge clk);
    if (track) begin
      exp_len   = (n > 64) ? 64 : n;
      exp_nak   = nl;
      req_cnt   = 0;
      delivered = 0;
    end
    ctl_wr    = 1'b1;
    ctl_wdata = {nl, 7'(n)};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_run;
    for (int i = 0; i < 3000 && delivered < exp_len; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pop_one(input string req);
    logic [7:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
    chk(rd_data == e, req, "popped byte", int'(rd_data), int'(e));
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  // monitor: drain and compare against the queue
  task automatic drain(input int n_exp);
    int got;
    got = 0;
    while (rx_empty == 1'b0 && got < 70) begin
      pop_one("R3");
      got++;
    end
    chk(got == n_exp, "R4", "bytes drained", got, n_exp);
    chk(exp_q.size() == 0, "R3", "no expected bytes left", exp_q.size(), 0);
    chk(rx_empty == 1'b1, "R4", "empty after drain", int'(rx_empty), 1);
  endtask

  task automatic isr_write(input logic [7:0] v);
    @(negedge clk);
    isr_wr = 1'b1;
    isr_wdata = v;
    @(negedge clk);
    isr_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
    isr_wr = 1'b0; isr_wdata = 8'h00;
    rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_empty == 1'b1, "R4", "reset empty", int'(rx_empty), 1);
    chk(rd_done == 1'b0, "R5", "reset flag", int'(rd_done), 0);
    chk(brx_req == 1'b0, "R1", "reset no request", int'(brx_req), 0);
    chk(rd_data == 8'h00, "R8", "reset data", int'(rd_data), 0);

    // R1/R3: five bytes, all acknowledged
    start_run(5, 1'b0, 1'b1);
    wait_run();
    chk(req_cnt == 5, "R1", "requests for 5", req_cnt, 5);
    chk(rx_empty == 1'b0, "R4", "not empty with data", int'(rx_empty), 0);
    drain(5);
    isr_write(8'hEF);
    chk(rd_done == 1'b1, "R5", "clear without bit4", int'(rd_done), 1);
    isr_write(8'h10);
    chk(rd_done == 1'b0, "R5", "clear with bit4", int'(rd_done), 0);

    // R2: three bytes, refuse the last
    start_run(3, 1'b1, 1'b1);
    wait_run();
    chk(req_cnt == 3, "R1", "requests for 3", req_cnt, 3);
    drain(3);
    isr_write(8'h10);

    // R6: zero count
    start_run(0, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R6", "no request for 0", req_cnt, 0);
    chk(rd_done == 1'b0, "R6", "no flag for 0", int'(rd_done), 0);

    // R7: write during a run
    start_run(4, 1'b0, 1'b1);
    @(negedge clk);
    start_run(2, 1'b1, 1'b0);
    wait_run();
    repeat (20) @(negedge clk);
    chk(req_cnt == 4, "R7", "mid-run write ignored", req_cnt, 4);
    drain(4);
    isr_write(8'h10);

    // R8: pop on empty
    chk(rd_data == 8'h00, "R8", "empty data zero", int'(rd_data), 0);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(rx_empty == 1'b1, "R8", "still empty after pop", int'(rx_empty), 1);
    start_run(1, 1'b1, 1'b1);
    wait_run();
    drain(1);
    isr_write(8'h10);

    // R9: count 100 clamps to 64, refuse the 64th
    start_run(100, 1'b1, 1'b1);
    wait_run();
    repeat (20) @(negedge clk);
    chk(req_cnt == 64, "R9", "clamped count", req_cnt, 64);
    isr_write(8'h10);

    // R10: queue full, run stalls
    start_run(2, 1'b0, 1'b1);
    repeat (15) @(negedge clk);
    chk(req_cnt == 0, "R10", "no request when full", req_cnt, 0);
    pop_one("R10");
    repeat (15) @(negedge clk);
    chk(delivered == 1, "R10", "one byte after one pop", delivered, 1);
    pop_one("R10");
    wait_run();
    chk(delivered == 2, "R10", "run completes", delivered, 2);
    drain(64);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule